// File: doc/BRIEF.md
# Multiprocessor Serial Receive Address Filter

This block sits behind the receive shifter of a serial port and decides whether a finished frame is handed to software. In multiprocessor networks a master sends address frames with the ninth data bit set and data frames with it clear. Each slave keeps a programmable station address and a bit mask. With multiprocessor filtering on, a slave only raises its receive-complete flag for an address frame that matches either its own masked address or a broadcast address. Once software recognises its address, it turns filtering off to receive the data frames that follow.

The mask marks which address bits are compared: a mask bit of 0 makes that bit don't care. The broadcast address is the station address OR'ed with the mask, and its zero bits are don't care. Both configuration registers come out of reset as zero, so every byte matches and the port acts as a plain receiver until software programs it. Independently of filtering, a stop bit sampled low raises a sticky framing-error flag.

Top module: `sio_addr_filter`

## Requirements
- R1: After reset, rxFlag, ferrFlag and ninthBit are 0, and both configuration registers are zero, so that any byte with ninth bit 1 is accepted in a filtered 9-bit mode.
- R2: In a 9-bit mode (mode values 2 and 3, i.e. mode[1]=1) with mpEn=1, a frame with rxNinth=1 whose byte equals the station address on every bit where the mask is 1 sets rxFlag one cycle after frameDone.
- R3: Under the same conditions, a byte that has a 1 in every bit position where (station address OR mask) is 1 is a broadcast match and sets rxFlag.
- R4: In a 9-bit mode with mpEn=1, a frame with rxNinth=0 never sets rxFlag, whatever its byte.
- R5: With mpEn=0, or in an 8-bit mode (mode values 0 and 1) whatever mpEn is, every completed frame sets rxFlag.
- R6: On an accepted frame ninthBit takes rxNinth in a 9-bit mode and is cleared to 0 in an 8-bit mode.
- R7: frameDone with stopBit=0 sets ferrFlag, whether or not the frame is accepted; ferrFlag stays set until a ferrClr pulse, and a new framing error wins over a clear in the same cycle.
- R8: While rxFlag is set and not being cleared, an arriving frame is dropped: rxFlag stays 1 and ninthBit is unchanged.
- R9: A rxFlagClr pulse clears rxFlag on the next cycle when no frame is accepted in that cycle.
- R10: In a 9-bit mode with mpEn=1, an address-frame byte that matches neither the masked station address nor the broadcast address leaves rxFlag at 0.
- R11: A cfgWrEn pulse writes cfgData to the station address when cfgSel=0 and to the mask when cfgSel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects station address, 1 selects mask |
| cfgData | input | 8 | Configuration write data |
| frameDone | input | 1 | One-cycle strobe: a frame has been shifted in |
| rxData | input | 8 | Received data byte |
| rxNinth | input | 1 | Received ninth bit |
| stopBit | input | 1 | Sampled stop bit value |
| mode | input | 2 | Port mode; mode[1]=1 means 9-bit frames |
| mpEn | input | 1 | Multiprocessor address filtering enable |
| rxFlagClr | input | 1 | Software clear of rxFlag |
| ferrClr | input | 1 | Software clear of ferrFlag |
| rxFlag | output | 1 | Receive-complete flag |
| ferrFlag | output | 1 | Sticky framing-error flag |
| ninthBit | output | 1 | Ninth bit of the last accepted frame |

## Verification
The bound checker keeps its own copy of the address and mask from the write port and checks on every cycle that masked and broadcast matches are accepted, that ninth-bit-zero frames are refused under filtering, that unfiltered frames always land, that a pending flag blocks new frames and that the error flag is sticky. The reset state, the exact addresses rejected by a programmed mask, the ninth-bit value left after mode changes and the interplay of errors with rejected frames are shown only by the bench's directed scenarios, which compare port values against hand-derived expectations.

// File: rtl/sio_filt_pkg.sv
package sio_filt_pkg;
  typedef struct packed {
    logic setRx;
    logic clrRx;
    logic setFerr;
    logic clrFerr;
    logic loadNinth;
    logic ninthVal;
  } filtStrobe_t;
endpackage

// File: rtl/sio_filt_dp.sv
module sio_filt_dp
  import sio_filt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [DATA_W-1:0] rxData,
  input  filtStrobe_t       strobe,
  output logic              matchGiven,
  output logic              matchBcast,
  output logic              rxFlag,
  output logic              ferrFlag,
  output logic              ninthBit
);
  logic [DATA_W-1:0] stationAddr;
  logic [DATA_W-1:0] careMask;
  logic [DATA_W-1:0] bcastAddr;
  logic [DATA_W-1:0] givenOk;
  logic [DATA_W-1:0] bcastOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stationAddr <= '0;
      careMask    <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) careMask    <= cfgData;
      else        stationAddr <= cfgData;
    end
  end

  assign bcastAddr = stationAddr | careMask;

  // Per-bit comparison: a bit passes when it is don't care or agrees.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign givenOk[b] = !careMask[b] || (rxData[b] == stationAddr[b]);
    assign bcastOk[b] = !bcastAddr[b] || rxData[b];
  end

  assign matchGiven = &givenOk;
  assign matchBcast = &bcastOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFlag   <= 1'b0;
      ferrFlag <= 1'b0;
      ninthBit <= 1'b0;
    end else begin
      if (strobe.setRx)        rxFlag <= 1'b1;
      else if (strobe.clrRx)   rxFlag <= 1'b0;
      if (strobe.setFerr)      ferrFlag <= 1'b1;
      else if (strobe.clrFerr) ferrFlag <= 1'b0;
      if (strobe.loadNinth)    ninthBit <= strobe.ninthVal;
    end
  end
endmodule

// File: rtl/sio_filt_ctrl.sv
module sio_filt_ctrl
  import sio_filt_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              frameDone,
  input  logic              stopBit,
  input  logic              rxNinth,
  input  logic [MODE_W-1:0] mode,
  input  logic              mpEn,
  input  logic              rxFlagClr,
  input  logic              ferrClr,
  input  logic              rxFlag,
  input  logic              matchGiven,
  input  logic              matchBcast,
  output filtStrobe_t       strobe
);
  logic nineBitMode;
  logic filtering;
  logic slotFree;
  logic addrOk;
  logic accept;

  always_comb begin
    nineBitMode = mode[MODE_W-1];
    filtering   = nineBitMode && mpEn;
    slotFree    = !rxFlag || rxFlagClr;
    addrOk      = !filtering || (rxNinth && (matchGiven || matchBcast));
    accept      = frameDone && slotFree && addrOk;

    strobe.setRx     = accept;
    strobe.clrRx     = rxFlagClr;
    strobe.setFerr   = frameDone && !stopBit;
    strobe.clrFerr   = ferrClr;
    strobe.loadNinth = accept;
    strobe.ninthVal  = nineBitMode && rxNinth;
  end
endmodule

// File: rtl/sio_addr_filter.sv
module sio_addr_filter
  import sio_filt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxNinth,
  input  logic              stopBit,
  input  logic [MODE_W-1:0] mode,
  input  logic              mpEn,
  input  logic              rxFlagClr,
  input  logic              ferrClr,
  output logic              rxFlag,
  output logic              ferrFlag,
  output logic              ninthBit
);
  filtStrobe_t strobe;
  logic        matchGiven;
  logic        matchBcast;

  sio_filt_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .frameDone (frameDone),
    .stopBit   (stopBit),
    .rxNinth   (rxNinth),
    .mode      (mode),
    .mpEn      (mpEn),
    .rxFlagClr (rxFlagClr),
    .ferrClr   (ferrClr),
    .rxFlag    (rxFlag),
    .matchGiven(matchGiven),
    .matchBcast(matchBcast),
    .strobe    (strobe)
  );

  sio_filt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .rxData    (rxData),
    .strobe    (strobe),
    .matchGiven(matchGiven),
    .matchBcast(matchBcast),
    .rxFlag    (rxFlag),
    .ferrFlag  (ferrFlag),
    .ninthBit  (ninthBit)
  );
endmodule

// File: rtl/sio_filt_chk.sv
module sio_filt_chk #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              cfgSel,
  input logic [DATA_W-1:0] cfgData,
  input logic              frameDone,
  input logic [DATA_W-1:0] rxData,
  input logic              rxNinth,
  input logic              stopBit,
  input logic [MODE_W-1:0] mode,
  input logic              mpEn,
  input logic              rxFlagClr,
  input logic              ferrClr,
  input logic              rxFlag,
  input logic              ferrFlag,
  input logic              ninthBit
);
  logic [DATA_W-1:0] shAddr;
  logic [DATA_W-1:0] shMask;
  logic              filt;
  logic              givenHit;
  logic              bcastHit;

  // R11: shadow copy of the configuration taken from the write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shAddr <= '0;
      shMask <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) shMask <= cfgData;
      else        shAddr <= cfgData;
    end
  end

  assign filt     = mode[MODE_W-1] && mpEn;
  assign givenHit = ((rxData ^ shAddr) & shMask) == '0;
  assign bcastHit = (~rxData & (shAddr | shMask)) == '0;

  assert_given_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && filt && rxNinth && !rxFlag && givenHit |=> rxFlag);

  assert_bcast_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && filt && rxNinth && !rxFlag && bcastHit |=> rxFlag);

  assert_ninth_zero_reject_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && filt && !rxNinth && !rxFlag |=> !rxFlag);

  assert_plain_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !filt && !rxFlag |=> rxFlag);

  assert_ninth_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !mode[MODE_W-1] && !rxFlag |=> !ninthBit);

  assert_ferr_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !stopBit |=> ferrFlag);

  assert_ferr_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    ferrFlag && !ferrClr |=> ferrFlag);

  assert_pending_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxFlag && !rxFlagClr |=> rxFlag && $stable(ninthBit));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxFlagClr && !frameDone |=> !rxFlag);

  assert_miss_reject_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && filt && !givenHit && !bcastHit && !rxFlag |=> !rxFlag);
endmodule

bind sio_addr_filter sio_filt_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
  .frameDone(frameDone), .rxData(rxData), .rxNinth(rxNinth), .stopBit(stopBit),
  .mode(mode), .mpEn(mpEn), .rxFlagClr(rxFlagClr), .ferrClr(ferrClr),
  .rxFlag(rxFlag), .ferrFlag(ferrFlag), .ninthBit(ninthBit)
);

// File: tb/sio_addr_filter_bench.sv
module sio_addr_filter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic       cfgSel = 1'b0;
  logic [7:0] cfgData = '0;
  logic       frameDone = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxNinth = 1'b0;
  logic       stopBit = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       mpEn = 1'b0;
  logic       rxFlagClr = 1'b0;
  logic       ferrClr = 1'b0;
  logic       rxFlag, ferrFlag, ninthBit;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sio_addr_filter u_sio_addr_filter (.*);

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic sel, input logic [7:0] val);
    @(negedge clk); cfgWrEn = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  // Drives one frameDone pulse; returns at the next falling edge,
  // after the register update of that pulse.
  task automatic sendFrame(input logic [1:0] md, input logic mp,
                           input logic [7:0] d, input logic n9, input logic stp);
    @(negedge clk);
    mode = md; mpEn = mp; rxData = d; rxNinth = n9; stopBit = stp; frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0; stopBit = 1'b1;
  endtask

  task automatic clearRx();
    @(negedge clk); rxFlagClr = 1'b1;
    @(negedge clk); rxFlagClr = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rxFlag after reset", rxFlag, 1'b0);
    check("R1 ferrFlag after reset", ferrFlag, 1'b0);
    check("R1 ninthBit after reset", ninthBit, 1'b0);
    sendFrame(2'd3, 1'b1, 8'h00, 1'b1, 1'b1);
    check("R1 zero config accepts any address", rxFlag, 1'b1);
    clearRx();
    check("R9 rxFlagClr clears flag", rxFlag, 1'b0);
  endtask

  task automatic testGiven();
    writeCfg(1'b0, 8'hC5);   // R11 station address
    writeCfg(1'b1, 8'hF0);   // R11 mask: upper nibble compared
    sendFrame(2'd2, 1'b1, 8'hC9, 1'b1, 1'b1);
    check("R2 masked station match accepted", rxFlag, 1'b1);
    check("R6 ninthBit from 9-bit frame", ninthBit, 1'b1);
    clearRx();
  endtask

  task automatic testBroadcast();
    sendFrame(2'd3, 1'b1, 8'hF7, 1'b1, 1'b1);
    check("R3 broadcast match accepted", rxFlag, 1'b1);
    clearRx();
  endtask

  task automatic testMiss();
    sendFrame(2'd2, 1'b1, 8'hD5, 1'b1, 1'b1);
    check("R10 non-matching address rejected", rxFlag, 1'b0);
    sendFrame(2'd2, 1'b1, 8'h35, 1'b1, 1'b1);
    check("R10 second non-matching address rejected", rxFlag, 1'b0);
  endtask

  task automatic testNinthZero();
    sendFrame(2'd3, 1'b1, 8'hC9, 1'b0, 1'b1);
    check("R4 data frame ignored under filtering", rxFlag, 1'b0);
    check("R4 ninthBit untouched by rejected frame", ninthBit, 1'b1);
  endtask

  task automatic testPlain();
    sendFrame(2'd2, 1'b0, 8'hD5, 1'b0, 1'b1);
    check("R5 unfiltered 9-bit frame accepted", rxFlag, 1'b1);
    check("R6 ninthBit takes 0 from 9-bit frame", ninthBit, 1'b0);
    clearRx();
    sendFrame(2'd3, 1'b1, 8'hC9, 1'b1, 1'b1);
    check("R6 ninthBit set again", ninthBit, 1'b1);
    clearRx();
    sendFrame(2'd1, 1'b1, 8'hD5, 1'b1, 1'b1);
    check("R5 8-bit mode ignores mpEn", rxFlag, 1'b1);
    check("R6 ninthBit cleared in 8-bit mode", ninthBit, 1'b0);
    clearRx();
  endtask

  task automatic testHold();
    sendFrame(2'd2, 1'b1, 8'hC9, 1'b1, 1'b1);
    check("R8 first frame accepted", rxFlag, 1'b1);
    sendFrame(2'd0, 1'b0, 8'h12, 1'b0, 1'b1);
    check("R8 flag stays set", rxFlag, 1'b1);
    check("R8 ninthBit unchanged by dropped frame", ninthBit, 1'b1);
    clearRx();
    check("R9 flag cleared", rxFlag, 1'b0);
  endtask

  task automatic testFerr();
    sendFrame(2'd3, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R7 framing error on rejected frame", ferrFlag, 1'b1);
    check("R7 rejected frame leaves rxFlag clear", rxFlag, 1'b0);
    sendFrame(2'd1, 1'b0, 8'h55, 1'b0, 1'b1);
    check("R7 ferrFlag sticky", ferrFlag, 1'b1);
    clearRx();
    @(negedge clk); ferrClr = 1'b1;
    @(negedge clk); ferrClr = 1'b0;
    check("R7 ferrClr clears", ferrFlag, 1'b0);
    @(negedge clk);
    ferrClr = 1'b1; frameDone = 1'b1; stopBit = 1'b0; mode = 2'd1; mpEn = 1'b0;
    @(negedge clk); ferrClr = 1'b0; frameDone = 1'b0; stopBit = 1'b1;
    check("R7 set wins over clear", ferrFlag, 1'b1);
    clearRx();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGiven();
    testBroadcast();
    testMiss();
    testNinthZero();
    testPlain();
    testHold();
    testFerr();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule